// File: doc/BRIEF.md
# Arithmetic and Logic Unit with Status Flags

This block is the arithmetic and logic stage of a small 32-bit datapath. Each cycle it takes two operands and a 3-bit operation code. It returns a combinational result along with a set of six status flags for that result. The flags go into a flags register on a rising clock edge, but only while the flag write enable is high. Held flags are visible at a port, so a following instruction or a branch unit can read them.

The add-with-carry and subtract-with-borrow operations take their carry or borrow input from the stored carry flag. A chain of these operations can therefore work on numbers wider than one word. Along with the usual carry, overflow, sign and zero flags, the unit gives two more. One is a nibble auxiliary carry, which decimal-adjust sequences need. The other is an even-parity flag over the low byte of the result.

Top module: `alu_flags_unit`

## Requirements
- R1: With opcode 0 (add) the result is A+B modulo 2^32. With opcode 1 (add with carry) the result is A+B+C modulo 2^32, where C is the stored carry flag.
- R2: With opcode 2 (subtract) the result is A-B modulo 2^32. With opcode 3 (subtract with borrow) the result is A-B-C modulo 2^32, where C is the stored carry flag.
- R3: Opcodes 4, 5 and 6 give the bitwise AND, OR and XOR of A and B. Opcode 7 passes A through unchanged.
- R4: On add and add-with-carry, the carry flag is 1 when the unsigned sum exceeds 2^32-1. On subtract and subtract-with-borrow it is 1 when unsigned A is less than B plus the borrow in.
- R5: On the four arithmetic operations, the overflow flag is 1 when the exact signed result lies outside -2^31 to 2^31-1.
- R6: The sign flag equals bit 31 of the result. The zero flag is 1 exactly when the result is zero.
- R7: On additions, the auxiliary flag is 1 when the low-nibble sum (plus carry in) exceeds 15. On subtractions it is 1 when the low nibble of A is less than the low nibble of B plus the borrow in.
- R8: The parity flag is 1 when bits 7:0 of the result hold an even number of ones.
- R9: Logic and pass operations clear carry, overflow and auxiliary, and set sign, zero and parity from the result.
- R10: The flags register loads only on a rising edge with flag_we high, and otherwise holds its value. A synchronous active-low reset clears it to all zeros, and reset takes precedence over flag_we.
- R11: The flags output holds carry in bit 0, parity in bit 1, auxiliary in bit 2, zero in bit 3, sign in bit 4 and overflow in bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the flags register |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_code | input | 3 | Operation select |
| flag_we | input | 1 | Flags register write enable |
| result | output | 32 | Combinational result |
| flags | output | 6 | Registered status flags |

## Verification
Directed operands are chosen at range edges: all-ones plus one, the largest positive plus one, zero minus one, and the most negative minus one. Between them, these four cases separate carry from overflow, and sign from zero, on both addition and subtraction. Nibble-edge operands such as 0x0F plus 0x01 and 0x10 minus 0x01 isolate the auxiliary carry and borrow from the word carry. Chained carry and borrow sequences show that the stored carry, not an input, feeds the second operation. A long run of pseudo-random operands, opcodes and write enables is also compared every cycle against a behavioural model. Some of its operands are drawn from corner values, and this run separates loading from holding and covers parity on many low-byte patterns.

// File: rtl/alu_flag_pkg.sv
// Package: shared opcode encoding and flag layout for the ALU.
// Assumes: the flag struct order is the port bit order (msb first).
package alu_flag_pkg;

    localparam int OP_W   = 3;
    localparam int FLAG_N = 6;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBB = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_PASS = 3'd7
    } alu_op_e;

    // bit 5 .. bit 0
    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic aux;
        logic parity;
        logic carry;
    } alu_flags_t;

endpackage

// File: rtl/alu_arith.sv
// Module: alu_arith
// Shared adder for add and subtract. Subtraction is done as A + ~B + ~borrow,
// and the carry and nibble carry outputs are inverted back into borrows.
// Assumes: WIDTH >= 5 so that bit 4 exists for the nibble carry.
module alu_arith #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             is_sub,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             carry,
    output logic             aux,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             c_eff;
    logic             c_out;

    // Operand conditioning: invert B and the carry in for subtraction.
    always_comb begin
        b_eff = is_sub ? ~b : b;
        c_eff = is_sub ? ~cin : cin;
    end

    // Single full-width add with a carry out.
    always_comb begin
        {c_out, sum} = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
    end

    // Flags: the carry into bit 4 is recovered from the sum bit and its inputs.
    always_comb begin
        carry = is_sub ? ~c_out : c_out;
        aux   = is_sub ? ~(a[4] ^ b_eff[4] ^ sum[4]) : (a[4] ^ b_eff[4] ^ sum[4]);
        ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end

endmodule

// File: rtl/alu_logic.sv
// Module: alu_logic
// Bitwise unit: AND, OR, XOR and pass-through of A, chosen by a 2-bit select.
// Assumes: the select is the low two opcode bits of a logic-class opcode.
module alu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] y
);
    // Bitwise function select.
    always_comb begin
        unique case (sel)
            2'd0:    y = a & b;
            2'd1:    y = a | b;
            2'd2:    y = a ^ b;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/alu_flag_gen.sv
// Module: alu_flag_gen
// Forms the next flag set from the selected result and the adder flags.
// Logic-class operations force carry, overflow and auxiliary to zero.
// Assumes: PAR_W is between 1 and WIDTH; parity is even parity over result[PAR_W-1:0].
module alu_flag_gen
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int PAR_W = 8
) (
    input  logic [WIDTH-1:0] res,
    input  logic             is_logic,
    input  logic             ar_carry,
    input  logic             ar_aux,
    input  logic             ar_ovf,
    output alu_flags_t       nxt
);
    logic par_even;

    // Parity window: the whole word, or only its low slice.
    generate
        if (PAR_W >= WIDTH) begin : g_par_full
            assign par_even = ~^res;
        end else begin : g_par_low
            assign par_even = ~^res[PAR_W-1:0];
        end
    endgenerate

    // Assemble the flag set for this cycle.
    always_comb begin
        nxt.carry  = is_logic ? 1'b0 : ar_carry;
        nxt.aux    = is_logic ? 1'b0 : ar_aux;
        nxt.ovf    = is_logic ? 1'b0 : ar_ovf;
        nxt.sign   = res[WIDTH-1];
        nxt.zero   = (res == '0);
        nxt.parity = par_even;
    end

endmodule

// File: rtl/alu_flag_reg.sv
// Module: alu_flag_reg
// Flags register: loads on write enable and clears on a synchronous active-low reset.
// Assumes: reset wins over the write enable.
module alu_flag_reg
    import alu_flag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  alu_flags_t d,
    output alu_flags_t q
);
    // Flag storage with enable.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end

    // R10: without a write, the flags keep their value.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> (q == $past(q)));

    // R10: a write loads the presented flags.
    a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(d)));

    // R10: reset clears the flags.
    a_r10_clear: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

endmodule

// File: rtl/alu_flags_unit.sv
// Module: alu_flags_unit (top)
// Decodes the opcode, runs the adder and the logic unit in parallel, selects the
// result and registers the flags. The stored carry feeds carry-in and borrow-in.
// Assumes: opcodes follow alu_op_e; opcode bit 2 marks the logic class.
module alu_flags_unit
    import alu_flag_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int PAR_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [WIDTH-1:0]    op_a,
    input  logic [WIDTH-1:0]    op_b,
    input  logic [OP_W-1:0]     op_code,
    input  logic                flag_we,
    output logic [WIDTH-1:0]    result,
    output logic [FLAG_N-1:0]   flags
);
    alu_op_e          op;
    logic             is_sub;
    logic             use_cin;
    logic             is_logic;
    logic             cin;
    logic [WIDTH-1:0] ar_sum;
    logic [WIDTH-1:0] lg_y;
    logic             ar_carry;
    logic             ar_aux;
    logic             ar_ovf;
    alu_flags_t       flags_next;
    alu_flags_t       flags_q;

    // Opcode decode and the carry-in source.
    always_comb begin
        op       = alu_op_e'(op_code);
        is_logic = op_code[2];
        is_sub   = (op == OP_SUB) || (op == OP_SUBB);
        use_cin  = (op == OP_ADDC) || (op == OP_SUBB);
        cin      = use_cin & flags_q.carry;
    end

    alu_arith #(.WIDTH(WIDTH)) arith_i (
        .a      (op_a),
        .b      (op_b),
        .is_sub (is_sub),
        .cin    (cin),
        .sum    (ar_sum),
        .carry  (ar_carry),
        .aux    (ar_aux),
        .ovf    (ar_ovf)
    );

    alu_logic #(.WIDTH(WIDTH)) logic_i (
        .a   (op_a),
        .b   (op_b),
        .sel (op_code[1:0]),
        .y   (lg_y)
    );

    // Result select between the adder and the logic unit.
    always_comb begin
        result = is_logic ? lg_y : ar_sum;
    end

    alu_flag_gen #(.WIDTH(WIDTH), .PAR_W(PAR_W)) flag_gen_i (
        .res      (result),
        .is_logic (is_logic),
        .ar_carry (ar_carry),
        .ar_aux   (ar_aux),
        .ar_ovf   (ar_ovf),
        .nxt      (flags_next)
    );

    alu_flag_reg flag_reg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (flag_we),
        .d     (flags_next),
        .q     (flags_q)
    );

    // Flag vector out in struct order.
    always_comb begin
        flags = flags_q;
    end

    // R9: logic class never reports carry, overflow or auxiliary.
    a_r9_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |-> !(flags_next.carry || flags_next.ovf || flags_next.aux));

    // R4: a plain add carries exactly when the sum wrapped below A.
    a_r4_add_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD) |-> (flags_next.carry == (result < op_a)));

    // R4: a plain subtract borrows exactly when A < B.
    a_r4_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SUB) |-> (flags_next.carry == (op_a < op_b)));

    // R7: on a plain add, the nibble carry equals the carry into bit 4.
    a_r7_add_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADD) |-> (flags_next.aux == (result[4] ^ op_a[4] ^ op_b[4])));

    // R3: pass-through returns A.
    a_r3_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PASS) |-> (result == op_a));

endmodule

// File: tb/alu_flags_unit_tb_top.sv
`timescale 1ns/1ps
module alu_flags_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [2:0]  op_code = '0;
    logic        flag_we = 1'b0;
    logic [31:0] result;
    logic [5:0]  flags;

    int checks = 0;
    int failures = 0;

    logic [5:0] mflags = '0;     // model flags register
    logic       last_load = 1'b1; // previous edge loaded or reset

    always #2 clk = ~clk;

    alu_flags_unit dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_a    (op_a),
        .op_b    (op_b),
        .op_code (op_code),
        .flag_we (flag_we),
        .result  (result),
        .flags   (flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // Behavioural model: result and next flags {ovf,sign,zero,aux,parity,carry}.
    task automatic model(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                         input logic c_st, output logic [31:0] r, output logic [5:0] f);
        longint ua, ub, us, sa, sb, ss;
        longint cin;
        int     ones;
        logic   c, o, x, p;
        ua  = longint'({32'b0, a});
        ub  = longint'({32'b0, b});
        sa  = longint'($signed(a));
        sb  = longint'($signed(b));
        cin = ((op == 3'd1) || (op == 3'd3)) ? longint'(c_st) : 0;
        c = 0; o = 0; x = 0;
        case (op)
            3'd0, 3'd1: begin
                us = ua + ub + cin;
                r  = us[31:0];
                c  = (us > 64'sd4294967295);
                ss = sa + sb + cin;
                o  = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
                x  = ((ua % 16) + (ub % 16) + cin) > 15;
            end
            3'd2, 3'd3: begin
                us = ua - ub - cin;
                r  = us[31:0];
                c  = ua < (ub + cin);
                ss = sa - sb - cin;
                o  = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
                x  = (ua % 16) < ((ub % 16) + cin);
            end
            3'd4: r = a & b;
            3'd5: r = a | b;
            3'd6: r = a ^ b;
            default: r = a;
        endcase
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(r[i]);
        p = (ones % 2) == 0;
        f = {o, r[31], (r == 32'd0), x, p, c};
    endtask

    // One cycle: check stored flags, drive, check result, clock the model.
    task automatic step(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op,
                        input logic we, input logic rst);
        logic [31:0] er;
        logic [5:0]  ef;
        string       rtag;
        @(negedge clk);
        if (last_load) begin
            chk("R11 flags vector", {26'b0, flags}, {26'b0, mflags});
            chk("R4 carry", {31'b0, flags[0]}, {31'b0, mflags[0]});
            chk("R8 parity", {31'b0, flags[1]}, {31'b0, mflags[1]});
            chk("R7 aux", {31'b0, flags[2]}, {31'b0, mflags[2]});
            chk("R6 zero", {31'b0, flags[3]}, {31'b0, mflags[3]});
            chk("R6 sign", {31'b0, flags[4]}, {31'b0, mflags[4]});
            chk("R5 overflow", {31'b0, flags[5]}, {31'b0, mflags[5]});
        end else begin
            chk("R10 flags held", {26'b0, flags}, {26'b0, mflags});
        end
        op_a = a; op_b = b; op_code = op; flag_we = we; rst_n = ~rst;
        #1;
        model(a, b, op, mflags[0], er, ef);
        rtag = (op < 3'd2) ? "R1 add result" : (op < 3'd4) ? "R2 sub result" : "R3 logic result";
        chk(rtag, result, er);
        @(posedge clk);
        if (rst) begin
            mflags = '0; last_load = 1'b1;
        end else if (we) begin
            mflags = ef; last_load = 1'b1;
        end else begin
            last_load = 1'b0;
        end
    endtask

    function automatic logic [31:0] pick(input logic [31:0] rnd, input logic [2:0] s);
        case (s)
            3'd0: pick = 32'hFFFF_FFFF;
            3'd1: pick = 32'h7FFF_FFFF;
            3'd2: pick = 32'h8000_0000;
            3'd3: pick = 32'h0000_000F;
            3'd4: pick = 32'd0;
            default: pick = rnd;
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        @(posedge clk);
        step(32'h1, 32'h2, 3'd0, 1'b1, 1'b1);                 // R10 reset wins over we
        step(32'hFFFF_FFFF, 32'h1, 3'd0, 1'b1, 1'b0);         // R4 carry, R6 zero, R7 aux
        step(32'h7FFF_FFFF, 32'h1, 3'd0, 1'b1, 1'b0);         // R5 ovf, R6 sign
        step(32'h0000_000F, 32'h1, 3'd0, 1'b1, 1'b0);         // R7 nibble carry only
        step(32'hFFFF_FFFF, 32'h0, 3'd0, 1'b1, 1'b0);         // set carry? no: clears
        step(32'hFFFF_FFFF, 32'h1, 3'd0, 1'b1, 1'b0);         // carry = 1
        step(32'h0000_0005, 32'h3, 3'd1, 1'b1, 1'b0);         // R1 adc uses stored carry
        step(32'h0, 32'h1, 3'd2, 1'b1, 1'b0);                 // R4 borrow, R2
        step(32'h10, 32'h1, 3'd3, 1'b1, 1'b0);                // R2 sbb with borrow, R7
        step(32'h8000_0000, 32'h1, 3'd2, 1'b1, 1'b0);         // R5 sub ovf
        step(32'h5, 32'h5, 3'd2, 1'b1, 1'b0);                 // R6 zero on sub
        step(32'h0, 32'h1, 3'd2, 1'b1, 1'b0);                 // carry = 1
        step(32'hF0F0_1234, 32'h0FF0_00FF, 3'd4, 1'b1, 1'b0); // R9 AND clears
        step(32'h0, 32'h1, 3'd2, 1'b1, 1'b0);
        step(32'h8000_0000, 32'h0000_0003, 3'd5, 1'b1, 1'b0); // R9 OR, R8
        step(32'hAAAA_AAAA, 32'hAAAA_AAAA, 3'd6, 1'b1, 1'b0); // XOR to zero
        step(32'h8765_4321, 32'h0, 3'd7, 1'b1, 1'b0);         // R3 pass
        step(32'hFFFF_FFFF, 32'h1, 3'd0, 1'b0, 1'b0);         // R10 no write
        step(32'h1, 32'h1, 3'd0, 1'b0, 1'b0);                 // R10 held
        step(32'hFFFF_FFFF, 32'h1, 3'd0, 1'b1, 1'b1);         // R10 reset
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] ra, rb;
            ra = pick($urandom(), 3'($urandom_range(0, 7)));
            rb = pick($urandom(), 3'($urandom_range(0, 7)));
            step(ra, rb, 3'($urandom_range(0, 7)), ($urandom_range(0, 3) != 0),
                 ($urandom_range(0, 99) == 0));
        end
        step(32'h0, 32'h0, 3'd0, 1'b0, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule